// File: doc/BRIEF.md
# MDIO Management Master

This block is a Clause 22 management-bus master. Software controls it through two 32-bit registers: a command register and a timing register. It generates the management clock and serializes one complete frame for each command. A frame is a preamble, start, opcode, PHY address, register address, turnaround and 16 data bits. The data line uses split out, output-enable and in pins, so the pad tri-state sits outside the block.

A frame is launched by one command-register write with the busy bit set. Software then polls the busy bit until it reads zero. After a read, the returned PHY value sits in the low half of the command register. Writing zero to the command register during a frame aborts the frame at once. The timing register sets the clock divider and the delays, in system-clock cycles, at which the master changes its output and samples the PHY's data.

Top module: `mdio_master`

## Requirements
- R1: Command register (`reg_addr`=0) fields: data [15:0], register address [20:16], PHY address [25:21], opcode [27:26], start [28], busy [30]. A write with bit 30 set while idle starts a frame, and bit 30 reads back as 1 while the frame runs. After reset both registers read as zero and MDC and output enable are low.
- R2: Each frame is sent MSB first as 32 ones, start `01`, opcode, 5-bit PHY address, 5-bit register address, turnaround and 16 data bits. For a write (opcode `01`) the turnaround is `10`, the data come from bits [15:0], and output enable stays high from the first bit to the last.
- R3: Timing register (`reg_addr`=1) bits [15:8] hold the period value P. The MDC high and low phases each last P+1 system clocks. MDC rests low whenever no frame is running.
- R4: Bits [31:24] of the timing register hold the output delay D. A driven bit changes D+1 clocks after the edge at which MDC falls. The delay must not exceed P.
- R5: For a read (opcode `10`), output enable drops in the first turnaround bit and stays low to the end of the frame. The 16 data bits are sampled I+1 clocks after each MDC rise, where I is timing bits [23:16] and I ≤ P. They land in bits [15:0], first bit received as bit 15.
- R6: Busy reads 1 for exactly 128*(P+1) clocks after the launching write and then clears, with MDC low and output enable low.
- R7: Writing 0 to the command register while busy returns the block to idle on the next clock: the register reads 0, MDC is low and output enable is low.
- R8: While busy, any other command write and any timing write is ignored. The running frame and the register contents are unchanged.
- R9: While idle, the timing register reads back the last value written to it. A command write without bit 30 is stored but starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = command register, 1 = timing register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Contents of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The assertions check on every cycle that MDC rests low and the output is released while idle, that MDC holds steady inside a phase, and that the divider count never passes P. They also check that a write keeps the line driven, that a read keeps it released from the second turnaround bit onward, and that non-abort writes during a frame leave the command fields alone. Only the bench scenarios can show frame content bit by bit, returned read data, the exact busy length, the output-change delay and the abort's effect. They do this with a PHY model that captures at each MDC rise and answers reads at each MDC fall.

// File: rtl/mdio_master.sv
module mdio_master (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [31:0] gw, cfg;
  logic [7:0]  cnt;
  logic [5:0]  slot;
  logic        mdc_q, out_q, oe_q;

  wire       busy    = gw[30];
  wire [7:0] per     = cfg[15:8];
  wire [7:0] in_dly  = cfg[23:16];
  wire [7:0] out_dly = cfg[31:24];
  wire       is_rd   = (gw[27:26] == 2'b10);

  wire gw_wr     = reg_wr && !reg_addr;
  wire launch    = gw_wr && !busy && reg_wdata[30];
  wire abort     = gw_wr && busy && (reg_wdata == 32'd0);
  wire phase_end = busy && (cnt == per);
  wire frame_end = phase_end && mdc_q && (slot == 6'd63);
  wire drive_pt  = busy && !mdc_q && (cnt == out_dly);
  wire samp_pt   = busy && mdc_q && (cnt == in_dly) && is_rd && (slot >= 6'd48);

  wire [63:0] frame = {32'hFFFF_FFFF, 2'b01, gw[27:26], gw[25:21], gw[20:16], 2'b10, gw[15:0]};

  assign reg_rdata = reg_addr ? cfg : gw;
  assign mdc       = mdc_q;
  assign mdio_o    = out_q;
  assign mdio_oe   = oe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gw  <= '0;
      cfg <= '0;
    end else begin
      if (gw_wr && (!busy || abort)) gw <= reg_wdata;
      else begin
        if (samp_pt)   gw[15:0] <= {gw[14:0], mdio_i};
        if (frame_end) gw[30]   <= 1'b0;
      end
      if (reg_wr && reg_addr && !busy) cfg <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || launch || abort || !busy) begin
      cnt   <= '0;
      slot  <= '0;
      mdc_q <= 1'b0;
    end else if (phase_end) begin
      cnt   <= '0;
      mdc_q <= ~mdc_q;
      if (mdc_q) slot <= slot + 6'd1;
    end else begin
      cnt <= cnt + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || abort || frame_end) begin
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (drive_pt) begin
      out_q <= frame[6'd63 - slot];
      oe_q  <= !(is_rd && slot >= 6'd46);
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !gw[30] |-> (!mdc_q && !oe_q)); // R3
  AST_PHASE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (gw[30] && cnt != 8'd0) |-> $stable(mdc_q)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    gw[30] |-> (cnt <= per)); // R3
  AST_WR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (gw[30] && !is_rd && slot >= 6'd1) |-> oe_q); // R2
  AST_RD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (gw[30] && is_rd && slot >= 6'd47) |-> !oe_q); // R5
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (gw_wr && gw[30] && reg_wdata != 32'd0) |=> (gw[29:16] == $past(gw[29:16]))); // R8
endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // {op[51:50], phy[49:45], reg[44:40], data[39:24], per[23:16], in[15:8], out[7:0]}
  localparam logic [51:0] VEC [NVEC] = '{
    {2'b01, 5'h01, 5'h02, 16'hA5C3, 8'd3, 8'd1, 8'd2},
    {2'b10, 5'h1F, 5'h00, 16'h8001, 8'd2, 8'd0, 8'd0},
    {2'b01, 5'h10, 5'h1F, 16'h0000, 8'd0, 8'd0, 8'd0},
    {2'b10, 5'h00, 5'h1F, 16'h5A3C, 8'd5, 8'd5, 8'd3},
    {2'b01, 5'h0A, 5'h15, 16'hFFFF, 8'd1, 8'd1, 8'd1}
  };

  logic clk = 0, rst_n = 0, reg_wr = 0, reg_addr = 0, mdio_i = 1'b1;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mdc, mdio_o, mdio_oe;
  int checks = 0, fails = 0, cyc = 0;

  mdio_master u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #(CLK_PERIOD/2) clk = ~clk;

  // PHY model: capture on MDC rise, answer reads on MDC fall
  logic [63:0] cap_d, cap_oe;
  int npos = 0, base = 0;
  logic [15:0] phy_val = '0;
  always @(posedge mdc) begin
    cap_d  <= {cap_d[62:0], mdio_o};
    cap_oe <= {cap_oe[62:0], mdio_oe};
    npos   <= npos + 1;
  end
  always @(negedge mdc) begin
    int s;
    s = npos - base;
    if (s == 47) mdio_i = 1'b0;
    else if (s >= 48 && s <= 63) mdio_i = phy_val[63 - s];
    else mdio_i = 1'b1;
  end

  // timing monitor
  logic prev_mdc = 0, prev_o = 0, armed = 0;
  int last_fall = 0, out_meas = -1, hi_run = 0, hi_last = 0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (prev_mdc && !mdc) begin last_fall <= cyc; hi_last <= hi_run; end
    hi_run <= mdc ? hi_run + 1 : 0;
    if (armed && prev_o && !mdio_o) begin out_meas <= cyc - last_fall; armed <= 0; end
    prev_mdc <= mdc;
    prev_o   <= mdio_o;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_addr = 0; reg_wdata = '0;
  endtask

  function automatic logic [31:0] cmd(input logic [1:0] op, input logic [4:0] phy,
                                      input logic [4:0] rg, input logic [15:0] d);
    return {1'b0, 1'b1, 1'b0, 1'b1, op, phy, rg, d};
  endfunction

  task automatic launch(input logic [31:0] c);
    base = npos;
    armed = 1;
    out_meas = -1;
    wr(0, c);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (reg_rdata[30]) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset cmd", reg_rdata, 0);
    reg_addr = 1; #1;
    check("R1 reset cfg", reg_rdata, 0);
    reg_addr = 0;
    check("R1 reset mdc/oe", {mdc, mdio_oe}, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] op; logic [4:0] phy, rg; logic [15:0] d; logic [7:0] p, id, od;
      {op, phy, rg, d, p, id, od} = VEC[i];
      wr(1, {od, id, p, 8'h15});
      reg_addr = 1; #1;
      check("R9 cfg readback", reg_rdata, {od, id, p, 8'h15});
      reg_addr = 0;
      phy_val = d;
      launch(cmd(op, phy, rg, (op == 2'b10) ? 16'h0000 : d));
      check("R1 busy set", reg_rdata[30], 1);
      wait_idle(n);
      check("R6 busy length", n, 128 * (p + 1));
      check("R6 idle lines", {mdc, mdio_oe}, 0);
      check("R3 high phase", hi_last, p + 1);
      check("R4 output delay", out_meas, od + 1);
      if (op == 2'b01) begin
        check("R2 write frame", cap_d, {32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b10, d});
        check("R2 write oe", cap_oe, {64{1'b1}});
      end else begin
        check("R5 read data", reg_rdata[15:0], d);
        check("R5 read oe", cap_oe, {{46{1'b1}}, 18'd0});
      end
    end

    // R7 abort
    wr(1, {8'd1, 8'd1, 8'd3, 8'h00});
    launch(cmd(2'b01, 5'h03, 5'h04, 16'h1234));
    repeat (100) @(negedge clk);
    wr(0, 32'd0);
    check("R7 abort regs", reg_rdata, 0);
    check("R7 abort lines", {mdc, mdio_oe}, 0);
    repeat (20) @(negedge clk);
    check("R7 stays idle", {mdc, mdio_oe, reg_rdata[30]}, 0);

    // R8 ignored writes while busy
    launch(cmd(2'b01, 5'h06, 5'h07, 16'hC0DE));
    repeat (50) @(negedge clk);
    wr(0, cmd(2'b10, 5'h11, 5'h12, 16'hBEEF));
    wr(0, 32'h0000_0001);
    wr(1, {8'd0, 8'd0, 8'd9, 8'h00});
    reg_addr = 1; #1;
    check("R8 cfg unchanged", reg_rdata, {8'd1, 8'd1, 8'd3, 8'h00});
    reg_addr = 0; #1;
    check("R8 cmd unchanged", reg_rdata, cmd(2'b01, 5'h06, 5'h07, 16'hC0DE));
    wait_idle(n);
    check("R8 frame unchanged", cap_d, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h06, 5'h07, 2'b10, 16'hC0DE});

    // R9 store without launch
    wr(0, 32'h1234_5678 & ~32'h4000_0000);
    repeat (10) @(negedge clk);
    check("R9 stored no launch", {reg_rdata, mdc, mdio_oe}, {32'h1234_5678 & ~32'h4000_0000, 2'b00});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule